// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block holds a small set of virtual-to-physical page translations. Every slot can hold any page. Each slot stores a virtual page tag, a physical page number, an address-space number, a global flag and two per-privilege-mode permission masks, one for reads and one for writes. A lookup presents a virtual page number and the current address-space number. One cycle later the block returns hit, the slot index, the physical page and both masks.

New translations are written by a fill command. The fill always lands in the slot named by a round-robin pointer, which then moves on. A side port shows the slot under that pointer and can step the pointer without writing, so a refill agent can inspect or skip victims.

Three invalidation commands keep the array coherent with the page tables:
- Wipe everything.
- Drop every translation that belongs to a process, keeping the global ones.
- Drop one page in one address space.

Top module: `tlb_assoc_array`

## Requirements
- R1: After reset no slot is valid, the pointer reads 0, no lookup result is flagged, and every lookup misses until a fill occurs.
- R2: A slot matches when it is valid, its tag equals the lookup page number, and either its global flag is 1 or its stored address-space number equals the lookup one. A non-global slot with a different address-space number does not match.
- R3: A lookup request in one cycle gives `lkp_vld_o`=1 with its result in the next cycle. On a miss, `lkp_hit_o`, `lkp_idx_o`, `lkp_ppn_o` and both masks are all 0.
- R4: When several slots match, the lowest-numbered slot is reported.
- R5: An accepted fill writes the slot at the pointer, replacing any valid contents, and moves the pointer one place on. The pointer goes from N-1 back to 0.
- R6: Wipe-all clears every valid bit and returns the pointer to 0.
- R7: Process flush clears exactly the valid slots whose global flag is 0. Global slots keep answering lookups. The pointer is untouched.
- R8: Page flush clears every valid slot whose tag equals the given page and whose address-space number equals the given one or whose global flag is 1. Several slots may go in one command, and other slots stay.
- R9: A fill in the same cycle as any flush command is dropped. It writes nothing and does not move the pointer, though wipe-all still sets the pointer to 0.
- R10: The victim port always shows the pointer and the slot at it. `adv_i` moves the pointer one place, with the same wrap as R5, without changing any slot. A fill together with `adv_i` moves the pointer only one place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_req_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Lookup virtual page |
| lkp_asn_i | input | ASN_W | Lookup address-space number |
| lkp_vld_o | output | 1 | Lookup result valid |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_idx_o | output | IDX_W | Matching slot |
| lkp_ppn_o | output | PPN_W | Physical page of matching slot |
| lkp_rd_en_o | output | MODE_W | Read permission mask per mode |
| lkp_wr_en_o | output | MODE_W | Write permission mask per mode |
| ins_i | input | 1 | Fill request |
| ins_vpn_i | input | VPN_W | Fill tag |
| ins_ppn_i | input | PPN_W | Fill physical page |
| ins_asn_i | input | ASN_W | Fill address-space number |
| ins_glb_i | input | 1 | Fill global flag |
| ins_rd_en_i | input | MODE_W | Fill read mask |
| ins_wr_en_i | input | MODE_W | Fill write mask |
| flush_all_i | input | 1 | Wipe all slots |
| flush_proc_i | input | 1 | Drop non-global slots |
| flush_addr_i | input | 1 | Drop one page |
| flush_vpn_i | input | VPN_W | Page for page flush |
| flush_asn_i | input | ASN_W | Address space for page flush |
| adv_i | input | 1 | Step the pointer without writing |
| nxt_ptr_o | output | IDX_W | Current pointer |
| nxt_vld_o | output | 1 | Valid bit of slot at pointer |
| nxt_vpn_o | output | VPN_W | Tag of slot at pointer |
| nxt_ppn_o | output | PPN_W | Physical page of slot at pointer |
| nxt_asn_o | output | ASN_W | Address-space number of slot at pointer |
| nxt_glb_o | output | 1 | Global flag of slot at pointer |

## Verification
The bench goes after these corner cases:

- **Duplicate tags.** The same page is present under one address space in two slots. A wrong priority encoder would report slot 3 instead of slot 0.
- **Address-space number override.** Probing with a foreign address-space number separates a global slot from a private one. A design that ignores the global flag misses a global page. A design that ignores the address-space number hits on another process's page.
- **Process flush.** Global slots must survive it.
- **Page flush.** It must take two private slots and one global slot at once, while leaving alone a private slot of a different address space.
- **Pointer behaviour.** The pointer is driven through its wrap so that a fill overwrites a live slot, stepped by the skip input, and held against a fill that collides with a flush. A design that let the fill win would show a new valid slot and a moved pointer on the victim port.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 20;
  localparam int PPN_W  = 20;
  localparam int ASN_W  = 8;
  localparam int MODE_W = 4;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASN_W-1:0]  asn;
    logic              glb;
    logic [MODE_W-1:0] rd_en;
    logic [MODE_W-1:0] wr_en;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (clr_i)    ptr_q <= '0;
    else if (adv_i)    ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R5 / R10: single step with wrap
  a_r5_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

  a_r6_ptr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_q == '0);
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] req_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  tlb_ent_t               wr_ent_i,
  input  logic                   flush_all_i,
  input  logic                   flush_proc_i,
  input  logic                   flush_addr_i,
  input  logic [VPN_W-1:0]       flush_vpn_i,
  input  logic [ASN_W-1:0]       flush_asn_i,
  input  logic [VPN_W-1:0]       lkp_vpn_i,
  input  logic [ASN_W-1:0]       lkp_asn_i,
  output logic [NUM_ENTRIES-1:0] match_o,
  output logic [NUM_ENTRIES-1:0] vld_o,
  output tlb_ent_t               ent_o [NUM_ENTRIES]
);
  logic [NUM_ENTRIES-1:0] vld_q;
  logic [NUM_ENTRIES-1:0] addr_hit;
  logic [NUM_ENTRIES-1:0] kill;
  tlb_ent_t               ent_q [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));
    assign addr_hit[i] = vld_q[i] && (ent_q[i].vpn == flush_vpn_i) &&
                         (ent_q[i].glb || (ent_q[i].asn == flush_asn_i));
    assign kill[i] = flush_all_i || (flush_proc_i && !ent_q[i].glb) ||
                     (flush_addr_i && addr_hit[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     vld_q[i] <= 1'b0;
      else if (kill[i]) vld_q[i] <= 1'b0;
      else if (sel)    vld_q[i] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ent_q[i] <= '0;
      else if (sel) ent_q[i] <= wr_ent_i;
    end

    assign match_o[i] = vld_q[i] && (ent_q[i].vpn == lkp_vpn_i) &&
                        (ent_q[i].glb || (ent_q[i].asn == lkp_asn_i));
    assign ent_o[i] = ent_q[i];
  end

  assign vld_o = vld_q;

  logic [NUM_ENTRIES-1:0] glb_vec;
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) glb_vec[i] = ent_q[i].glb;
  end

  // R7: global slots survive a process flush
  a_r7_glb_survive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_proc_i && !flush_all_i) |=>
      ((vld_q & $past(vld_q & glb_vec)) == $past(vld_q & glb_vec)));

  // R8: no targeted slot remains valid
  a_r8_addr_gone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_addr_i |=> ((vld_q & $past(addr_hit)) == '0));
endmodule

// File: rtl/tlb_assoc_array.sv
module tlb_assoc_array
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_req_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASN_W-1:0]  lkp_asn_i,
  output logic              lkp_vld_o,
  output logic              lkp_hit_o,
  output logic [IDX_W-1:0]  lkp_idx_o,
  output logic [PPN_W-1:0]  lkp_ppn_o,
  output logic [MODE_W-1:0] lkp_rd_en_o,
  output logic [MODE_W-1:0] lkp_wr_en_o,
  input  logic              ins_i,
  input  logic [VPN_W-1:0]  ins_vpn_i,
  input  logic [PPN_W-1:0]  ins_ppn_i,
  input  logic [ASN_W-1:0]  ins_asn_i,
  input  logic              ins_glb_i,
  input  logic [MODE_W-1:0] ins_rd_en_i,
  input  logic [MODE_W-1:0] ins_wr_en_i,
  input  logic              flush_all_i,
  input  logic              flush_proc_i,
  input  logic              flush_addr_i,
  input  logic [VPN_W-1:0]  flush_vpn_i,
  input  logic [ASN_W-1:0]  flush_asn_i,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  nxt_ptr_o,
  output logic              nxt_vld_o,
  output logic [VPN_W-1:0]  nxt_vpn_o,
  output logic [PPN_W-1:0]  nxt_ppn_o,
  output logic [ASN_W-1:0]  nxt_asn_o,
  output logic              nxt_glb_o
);
  logic                   any_flush, ins_ok;
  logic [IDX_W-1:0]       ptr;
  tlb_ent_t               wr_ent;
  tlb_ent_t               ent [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] match, vld;
  logic                   any_hit;
  logic [IDX_W-1:0]       hit_idx;

  assign any_flush = flush_all_i | flush_proc_i | flush_addr_i;
  assign ins_ok    = ins_i & ~any_flush;

  always_comb begin
    wr_ent.vpn   = ins_vpn_i;
    wr_ent.ppn   = ins_ppn_i;
    wr_ent.asn   = ins_asn_i;
    wr_ent.glb   = ins_glb_i;
    wr_ent.rd_en = ins_rd_en_i;
    wr_ent.wr_en = ins_wr_en_i;
  end

  tlb_rr_ptr #(.NUM_ENTRIES(NUM_ENTRIES)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flush_all_i),
    .adv_i  (ins_ok | adv_i),
    .ptr_o  (ptr)
  );

  tlb_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) i_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (ins_ok),
    .wr_idx_i     (ptr),
    .wr_ent_i     (wr_ent),
    .flush_all_i  (flush_all_i),
    .flush_proc_i (flush_proc_i),
    .flush_addr_i (flush_addr_i),
    .flush_vpn_i  (flush_vpn_i),
    .flush_asn_i  (flush_asn_i),
    .lkp_vpn_i    (lkp_vpn_i),
    .lkp_asn_i    (lkp_asn_i),
    .match_o      (match),
    .vld_o        (vld),
    .ent_o        (ent)
  );

  tlb_prio_enc #(.NUM_ENTRIES(NUM_ENTRIES)) i_enc (
    .req_i (match),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  logic              res_vld_q, hit_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [MODE_W-1:0] rd_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_q <= 1'b0;
      hit_q     <= 1'b0;
      idx_q     <= '0;
      ppn_q     <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
    end else begin
      res_vld_q <= lkp_req_i;
      hit_q     <= lkp_req_i & any_hit;
      if (lkp_req_i && any_hit) begin
        idx_q <= hit_idx;
        ppn_q <= ent[hit_idx].ppn;
        rd_q  <= ent[hit_idx].rd_en;
        wr_q  <= ent[hit_idx].wr_en;
      end else begin
        idx_q <= '0;
        ppn_q <= '0;
        rd_q  <= '0;
        wr_q  <= '0;
      end
    end
  end

  assign lkp_vld_o   = res_vld_q;
  assign lkp_hit_o   = hit_q;
  assign lkp_idx_o   = idx_q;
  assign lkp_ppn_o   = ppn_q;
  assign lkp_rd_en_o = rd_q;
  assign lkp_wr_en_o = wr_q;

  assign nxt_ptr_o = ptr;
  assign nxt_vld_o = vld[ptr];
  assign nxt_vpn_o = ent[ptr].vpn;
  assign nxt_ppn_o = ent[ptr].ppn;
  assign nxt_asn_o = ent[ptr].asn;
  assign nxt_glb_o = ent[ptr].glb;

  a_r3_result_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> lkp_vld_o);

  a_r3_miss_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_vld_o && !lkp_hit_o) |-> (lkp_idx_o == '0 && lkp_ppn_o == '0 &&
                                   lkp_rd_en_o == '0 && lkp_wr_en_o == '0));

  a_r6_wipe_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (vld == '0 && nxt_ptr_o == '0));

  // R9: no slot becomes valid while a flush is applied
  a_r9_flush_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_flush |=> ((vld & ~$past(vld)) == '0));

  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_flush && !flush_all_i && !adv_i) |=> $stable(nxt_ptr_o));
endmodule

// File: tb/test_tlb_assoc_array.sv
`timescale 1ns/1ps
module test_tlb_assoc_array;
  import tlb_pkg::*;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              lkp_req, lkp_vld, lkp_hit;
  logic [VPN_W-1:0]  lkp_vpn;
  logic [ASN_W-1:0]  lkp_asn;
  logic [IW-1:0]     lkp_idx;
  logic [PPN_W-1:0]  lkp_ppn;
  logic [MODE_W-1:0] lkp_rd, lkp_wr;
  logic              ins, ins_glb;
  logic [VPN_W-1:0]  ins_vpn;
  logic [PPN_W-1:0]  ins_ppn;
  logic [ASN_W-1:0]  ins_asn;
  logic [MODE_W-1:0] ins_rd, ins_wr;
  logic              f_all, f_proc, f_addr, adv;
  logic [VPN_W-1:0]  f_vpn;
  logic [ASN_W-1:0]  f_asn;
  logic [IW-1:0]     nxt_ptr;
  logic              nxt_vld, nxt_glb;
  logic [VPN_W-1:0]  nxt_vpn;
  logic [PPN_W-1:0]  nxt_ppn;
  logic [ASN_W-1:0]  nxt_asn;

  tlb_assoc_array #(.NUM_ENTRIES(N)) i_tlb_assoc_array (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_req_i(lkp_req), .lkp_vpn_i(lkp_vpn), .lkp_asn_i(lkp_asn),
    .lkp_vld_o(lkp_vld), .lkp_hit_o(lkp_hit), .lkp_idx_o(lkp_idx),
    .lkp_ppn_o(lkp_ppn), .lkp_rd_en_o(lkp_rd), .lkp_wr_en_o(lkp_wr),
    .ins_i(ins), .ins_vpn_i(ins_vpn), .ins_ppn_i(ins_ppn), .ins_asn_i(ins_asn),
    .ins_glb_i(ins_glb), .ins_rd_en_i(ins_rd), .ins_wr_en_i(ins_wr),
    .flush_all_i(f_all), .flush_proc_i(f_proc), .flush_addr_i(f_addr),
    .flush_vpn_i(f_vpn), .flush_asn_i(f_asn), .adv_i(adv),
    .nxt_ptr_o(nxt_ptr), .nxt_vld_o(nxt_vld), .nxt_vpn_o(nxt_vpn),
    .nxt_ppn_o(nxt_ppn), .nxt_asn_o(nxt_asn), .nxt_glb_o(nxt_glb)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  bit       m_vld [N];
  tlb_ent_t m_ent [N];
  int       m_ptr = 0;

  typedef struct {
    bit                hit;
    int                idx;
    logic [PPN_W-1:0]  ppn;
    logic [MODE_W-1:0] rd, wr;
    string             req;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic idle_all();
    lkp_req = 0; lkp_vpn = '0; lkp_asn = '0;
    ins = 0; ins_vpn = '0; ins_ppn = '0; ins_asn = '0; ins_glb = 0;
    ins_rd = '0; ins_wr = '0;
    f_all = 0; f_proc = 0; f_addr = 0; f_vpn = '0; f_asn = '0; adv = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    idle_all();
  endtask

  task automatic do_insert(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p,
                           logic [ASN_W-1:0] a, bit g);
    @(negedge clk);
    ins = 1; ins_vpn = v; ins_ppn = p; ins_asn = a; ins_glb = g;
    ins_rd = p[3:0]; ins_wr = ~p[3:0];
    m_ent[m_ptr] = '{vpn: v, ppn: p, asn: a, glb: g, rd_en: p[3:0], wr_en: ~p[3:0]};
    m_vld[m_ptr] = 1;
    m_ptr = (m_ptr + 1) % N;
    cycle();
  endtask

  task automatic do_lookup(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, string req);
    exp_t e;
    @(negedge clk);
    lkp_req = 1; lkp_vpn = v; lkp_asn = a;
    e.hit = 0; e.idx = 0; e.ppn = '0; e.rd = '0; e.wr = '0; e.req = req;
    for (int i = 0; i < N; i++) begin
      if (!e.hit && m_vld[i] && m_ent[i].vpn == v && (m_ent[i].glb || m_ent[i].asn == a)) begin
        e.hit = 1; e.idx = i; e.ppn = m_ent[i].ppn;
        e.rd = m_ent[i].rd_en; e.wr = m_ent[i].wr_en;
      end
    end
    sbq.push_back(e);
    cycle();
  endtask

  // flush with optional colliding fill
  task automatic do_flush(bit fa, bit fp, bit fd, logic [VPN_W-1:0] v,
                          logic [ASN_W-1:0] a, bit with_ins);
    @(negedge clk);
    f_all = fa; f_proc = fp; f_addr = fd; f_vpn = v; f_asn = a;
    if (with_ins) begin
      ins = 1; ins_vpn = 20'h0EEEE; ins_ppn = 20'h0EEEE; ins_asn = 8'h55; ins_glb = 1;
    end
    for (int i = 0; i < N; i++) begin
      if (fa || (fp && !m_ent[i].glb) ||
          (fd && m_vld[i] && m_ent[i].vpn == v && (m_ent[i].glb || m_ent[i].asn == a)))
        m_vld[i] = 0;
    end
    if (fa) m_ptr = 0;
    cycle();
  endtask

  task automatic do_adv();
    @(negedge clk);
    adv = 1;
    m_ptr = (m_ptr + 1) % N;
    cycle();
  endtask

  task automatic chk_nxt(string req);
    @(negedge clk);
    chk(req, "nxt_ptr", nxt_ptr, m_ptr);
    chk(req, "nxt_vld", nxt_vld, m_vld[m_ptr]);
    if (m_vld[m_ptr]) begin
      chk(req, "nxt_vpn", nxt_vpn, m_ent[m_ptr].vpn);
      chk(req, "nxt_ppn", nxt_ppn, m_ent[m_ptr].ppn);
      chk(req, "nxt_asn", nxt_asn, m_ent[m_ptr].asn);
      chk(req, "nxt_glb", nxt_glb, m_ent[m_ptr].glb);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && lkp_vld) begin
      if (sbq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3 unexpected result: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.req, "hit", lkp_hit, e.hit);
        chk(e.req, "idx", lkp_idx, e.idx);
        chk(e.req, "ppn", lkp_ppn, e.ppn);
        chk(e.req, "rd_en", lkp_rd, e.rd);
        chk(e.req, "wr_en", lkp_wr, e.wr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_all();
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_ent[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1", "lkp_vld", lkp_vld, 0);
    chk_nxt("R1");
    do_lookup(20'h00100, 8'h01, "R1");

    do_insert(20'h00100, 20'h000A1, 8'h01, 0);
    do_insert(20'h00200, 20'h000B2, 8'h02, 1);
    do_insert(20'h00100, 20'h000C3, 8'h03, 0);
    do_insert(20'h00100, 20'h000D4, 8'h01, 0);
    do_lookup(20'h00100, 8'h01, "R4");   // slots 0 and 3 match
    do_lookup(20'h00100, 8'h03, "R2");
    do_lookup(20'h00100, 8'h05, "R2");   // asn mismatch
    do_lookup(20'h00200, 8'h09, "R2");   // global override
    chk_nxt("R5");

    do_flush(0, 1, 0, '0, '0, 0);
    do_lookup(20'h00100, 8'h01, "R7");
    do_lookup(20'h00200, 8'h00, "R7");
    chk_nxt("R7");

    for (int i = 0; i < 4; i++) do_insert(20'h01000 + 20'(i), 20'h00110 + 20'(i), 8'h07, 0);
    chk_nxt("R5");                         // wrapped to 0
    do_insert(20'h00400, 20'h00044, 8'h07, 0);
    do_insert(20'h00500, 20'h00055, 8'h07, 0); // overwrites global slot 1
    do_lookup(20'h00200, 8'h02, "R5");
    do_lookup(20'h00500, 8'h07, "R5");
    do_lookup(20'h01003, 8'h07, "R5");

    // page flush: slots 2,3 private asn4, slot 4 global, slot 5 asn6
    do_insert(20'h00300, 20'h00301, 8'h04, 0);
    do_insert(20'h00300, 20'h00302, 8'h04, 0);
    do_insert(20'h00300, 20'h00303, 8'h09, 1);
    do_insert(20'h00300, 20'h00304, 8'h06, 0);
    do_flush(0, 0, 1, 20'h00300, 8'h04, 0);
    do_lookup(20'h00300, 8'h04, "R8");
    do_lookup(20'h00300, 8'h06, "R8");
    do_lookup(20'h00300, 8'h09, "R8");
    do_lookup(20'h00400, 8'h07, "R8");

    // fill colliding with flush
    chk_nxt("R9");
    do_flush(0, 0, 1, 20'h0FFFF, 8'h00, 1);
    chk_nxt("R9");
    do_lookup(20'h0EEEE, 8'h55, "R9");

    do_adv();
    chk_nxt("R10");
    do_adv();
    do_adv();
    chk_nxt("R10");
    do_lookup(20'h00100, 8'h01, "R10");

    do_flush(1, 0, 0, '0, '0, 1);
    chk_nxt("R6");
    do_lookup(20'h00500, 8'h07, "R6");
    do_lookup(20'h0EEEE, 8'h55, "R6");
    do_insert(20'h00777, 20'h00777, 8'h01, 0);
    chk_nxt("R6");
    do_lookup(20'h00777, 8'h01, "R6");

    repeat (3) @(negedge clk);
    chk("R3", "pending", sbq.size(), 0);
    finish_run();
  end
endmodule